// File: doc/BRIEF.md
# Banked GPIO register controller

This block puts a large set of general-purpose I/O lines behind one 32-bit register port with APB-style signalling. The lines are grouped into banks of eight. Each bank has a data byte and a direction byte. A direction bit of 1 makes its line an input. A direction bit of 0 turns on the line's output enable, and the line then drives the stored data bit. Pin inputs pass through a two-flop synchronizer. A read of a data register returns, bit by bit, the synchronized pin level for input lines and the stored value for output lines.

Bank register pairs sit at a stride of eight bytes. Bank b nominally starts at (b+1)*8. Bytes 0x90 to 0x9F are kept for interrupt control. For that reason every bank whose nominal start falls at or above 0x90 is moved up by 0x10. A single interrupt-enable word at 0x90 is shared by all banks. The bank count is a parameter from 1 to 31, so the whole map fits in 512 bytes. Addresses of banks beyond the configured count decode as unmapped.

A small state machine runs the bus side. ST_IDLE waits for a setup cycle (psel high, penable low) and then moves to ST_ENABLE. ST_ENABLE is a wait cycle with pready low. If psel and penable are both high there, the write is committed or the read data is captured, and the machine moves to ST_COMPLETE. If either signal is low there, the transfer is abandoned and the machine returns to ST_IDLE. ST_COMPLETE drives pready high with the captured read data for one cycle and always returns to ST_IDLE.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction bit is 1, so pin_oe is all zero. Every data bit is 0, so pin_out is all zero. irq_en is zero. A direction register then reads 0xFF.
- R2: A transfer has three phases: a setup cycle, a wait cycle with pready low, and a completion cycle with pready high for exactly one cycle. prdata is zero in every cycle where pready is low.
- R3: Address bits [1:0] are ignored. For a bank b whose nominal start (b+1)*8 is below 0x90, the data register is at (b+1)*8 and the direction register is at (b+1)*8+4. Examples: bank 0 uses 0x08 and 0x0C, and bank 16 uses 0x88 and 0x8C.
- R4: For a bank b whose nominal start is 0x90 or above, both registers are moved up by 0x10. Examples: bank 17 uses 0xA0 and 0xA4, and bank 19 uses 0xB0 and 0xB4.
- R5: The word at 0x90 is a full 32-bit interrupt-enable register shared by all banks. It can be written and read back, and its value appears on irq_en.
- R6: The following offsets read as zero and ignore writes: 0x00 to 0x07, 0x94 to 0x9F, and any bank address at or beyond the configured bank count. Writes to these offsets leave every bank register untouched.
- R7: Only bits [7:0] of a bank register are stored. Bits [31:8] read as zero, and write data in those bits is dropped.
- R8: Line n belongs to bank n/8 at bit n%8. pin_oe[n] is the inverse of that direction bit. pin_out[n] is that stored data bit.
- R9: A data-register read returns the synchronized pin for bits whose direction is 1 and the stored bit for bits whose direction is 0. Pins pass two flops and the read is captured in the wait cycle. A pin change applied in the setup cycle of a read is therefore not seen by that read. A read that starts three cycles later sees it.
- R10: A write takes effect only when a setup cycle is followed by a cycle with psel and penable both high. A transfer dropped after setup, or an enable phase with no setup, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Enable phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W (9) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid while pready is high, else zero |
| pready | output | 1 | Transfer completion, one cycle |
| pin_in | input | NUM_BANKS*8 | Pin levels, asynchronous |
| pin_out | output | NUM_BANKS*8 | Stored output value per line |
| pin_oe | output | NUM_BANKS*8 | Output enable per line, 1 drives |
| irq_en | output | DATA_W (32) | Shared interrupt-enable word |

## Verification
The bench builds the controller with 20 banks. This is enough to cover banks on both sides of the reserved window: bank 16 ends just below it, and banks 17 to 19 sit above it with the 0x10 shift. It also leaves the slot that bank 20 would take, at 0xB8, free, so the cut-off for banks above the configured count can be tested. With this setting, the window offsets, the addresses below bank 0 and the first address past the last bank can all be checked against the neighbouring live registers.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int LINES_PER_BANK = 8;
    localparam int BANK_STRIDE    = 8;
    localparam int DIR_OFFSET     = 4;
    localparam int IRQ_WINDOW     = 'h90;
    localparam int WINDOW_SPAN    = 'h10;
    localparam int IRQ_WORD_SPAN  = 4;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ENABLE   = 2'd1,
        ST_COMPLETE = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_IRQ  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 31,
    parameter int ADDR_W    = 9,
    parameter int IDX_W     = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  bank_idx
);
    timeunit 1ns;
    timeprecision 100ps;

    always_comb begin
        int byte_ofs;
        int folded;
        int slot;
        byte_ofs = int'(addr);
        folded   = byte_ofs;
        slot     = 0;
        sel      = SEL_NONE;
        bank_idx = '0;
        if (byte_ofs >= IRQ_WINDOW && byte_ofs < IRQ_WINDOW + IRQ_WORD_SPAN) begin
            sel = SEL_IRQ;
        end else if (byte_ofs >= IRQ_WINDOW && byte_ofs < IRQ_WINDOW + WINDOW_SPAN) begin
            sel = SEL_NONE;
        end else begin
            folded = (byte_ofs >= IRQ_WINDOW + WINDOW_SPAN) ? byte_ofs - WINDOW_SPAN : byte_ofs;
            slot   = folded / BANK_STRIDE;
            if (slot >= 1 && slot <= NUM_BANKS) begin
                bank_idx = IDX_W'(slot - 1);
                sel      = ((folded % BANK_STRIDE) >= DIR_OFFSET) ? SEL_DIR : SEL_DATA;
            end
        end
    end
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [DATA_W-1:0] rd_value,
    output logic              wr_fire,
    output logic              pready,
    output logic [DATA_W-1:0] prdata
);
    timeunit 1ns;
    timeprecision 100ps;

    bus_state_e        state_q;
    bus_state_e        state_d;
    logic [DATA_W-1:0] capture_q;
    logic              enable_seen;

    assign enable_seen = psel && penable;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = (psel && !penable) ? ST_ENABLE : ST_IDLE;
            ST_ENABLE:   state_d = enable_seen ? ST_COMPLETE : ST_IDLE;
            ST_COMPLETE: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capture_q <= '0;
        end else if (state_q == ST_ENABLE && enable_seen) begin
            capture_q <= pwrite ? '0 : rd_value;
        end
    end

    always_comb begin
        wr_fire = 1'b0;
        pready  = 1'b0;
        prdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ENABLE:   wr_fire = enable_seen && pwrite;
            ST_COMPLETE: begin
                pready = 1'b1;
                prdata = capture_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 31,
    parameter int IDX_W     = 5,
    localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_fire,
    input  reg_sel_e                  sel,
    input  logic [IDX_W-1:0]          bank_idx,
    input  logic [LINES_PER_BANK-1:0] wr_byte,
    output logic [NUM_LINES-1:0]      data_q,
    output logic [NUM_LINES-1:0]      dir_q
);
    timeunit 1ns;
    timeprecision 100ps;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic                      hit;
        logic [LINES_PER_BANK-1:0] data_r;
        logic [LINES_PER_BANK-1:0] dir_r;

        assign hit = wr_fire && (int'(bank_idx) == b);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_r <= '0;
                dir_r  <= '1;
            end else begin
                if (hit && sel == SEL_DATA) data_r <= wr_byte;
                if (hit && sel == SEL_DIR)  dir_r  <= wr_byte;
            end
        end

        assign data_q[b*LINES_PER_BANK +: LINES_PER_BANK] = data_r;
        assign dir_q[b*LINES_PER_BANK +: LINES_PER_BANK]  = dir_r;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS   = 31,
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_LINES  = NUM_BANKS * LINES_PER_BANK,
    localparam int IDX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]    pwdata,
    output logic [DATA_W-1:0]    prdata,
    output logic                 pready,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic [DATA_W-1:0]    irq_en
);
    timeunit 1ns;
    timeprecision 100ps;

    reg_sel_e                  sel;
    logic [IDX_W-1:0]          bank_idx;
    logic                      wr_fire;
    logic [DATA_W-1:0]         rd_value;
    logic [NUM_LINES-1:0]      data_q;
    logic [NUM_LINES-1:0]      dir_q;
    logic [NUM_LINES-1:0]      pin_sync;
    logic [DATA_W-1:0]         irq_q;
    logic [LINES_PER_BANK-1:0] bank_dir;
    logic [LINES_PER_BANK-1:0] bank_data;
    logic [LINES_PER_BANK-1:0] bank_pin;

    gpio_addr_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) u_decode (
        .addr     (paddr),
        .sel      (sel),
        .bank_idx (bank_idx)
    );

    gpio_bus_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .rd_value (rd_value),
        .wr_fire  (wr_fire),
        .pready   (pready),
        .prdata   (prdata)
    );

    gpio_bank_regs #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .sel      (sel),
        .bank_idx (bank_idx),
        .wr_byte  (pwdata[LINES_PER_BANK-1:0]),
        .data_q   (data_q),
        .dir_q    (dir_q)
    );

    gpio_in_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else if (wr_fire && sel == SEL_IRQ) begin
            irq_q <= pwdata;
        end
    end

    always_comb begin
        bank_dir  = '0;
        bank_data = '0;
        bank_pin  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bank_idx) == b) begin
                bank_dir  = dir_q[b*LINES_PER_BANK +: LINES_PER_BANK];
                bank_data = data_q[b*LINES_PER_BANK +: LINES_PER_BANK];
                bank_pin  = pin_sync[b*LINES_PER_BANK +: LINES_PER_BANK];
            end
        end
    end

    always_comb begin
        rd_value = '0;
        unique case (sel)
            SEL_NONE: rd_value = '0;
            SEL_DATA: rd_value = DATA_W'((bank_dir & bank_pin) | (~bank_dir & bank_data));
            SEL_DIR:  rd_value = DATA_W'(bank_dir);
            SEL_IRQ:  rd_value = irq_q;
            default:  rd_value = '0;
        endcase
    end

    assign pin_out = data_q;
    assign pin_oe  = ~dir_q;
    assign irq_en  = irq_q;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NUM_LINES = 8,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic                 pready,
    input logic [DATA_W-1:0]    prdata,
    input logic [NUM_LINES-1:0] pin_out,
    input logic [NUM_LINES-1:0] pin_oe,
    input logic [DATA_W-1:0]    irq_en
);
    timeunit 1ns;
    timeprecision 100ps;

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && irq_en == '0));

    p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pready |=> !pready);

    p_ready_after_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pready) |-> $past(psel && penable));

    p_rdata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pready |-> prdata == '0);

    p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(psel && penable && pwrite) |-> ($stable(pin_oe) && $stable(pin_out) && $stable(irq_en)));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .pready  (pready),
    .prdata  (prdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq_en  (irq_en)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NB = 20;
    localparam int NL = NB * 8;

    typedef struct packed {
        logic        wr;
        logic [8:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 9'h00C, 32'h0000000F, 32'h0,        4'd3},  // R3 bank0 dir
        '{1'b0, 9'h00C, 32'h0,        32'h0000000F, 4'd3},
        '{1'b1, 9'h008, 32'hFFFFFFA5, 32'h0,        4'd7},  // R7 upper bits dropped
        '{1'b0, 9'h008, 32'h0,        32'h000000A0, 4'd9},  // R9 inputs read pins (0)
        '{1'b1, 9'h08C, 32'h00000000, 32'h0,        4'd3},  // bank16 all out
        '{1'b1, 9'h088, 32'h0000003C, 32'h0,        4'd3},
        '{1'b0, 9'h088, 32'h0,        32'h0000003C, 4'd3},
        '{1'b1, 9'h090, 32'hDEADBEEF, 32'h0,        4'd5},  // R5 shared word
        '{1'b0, 9'h090, 32'h0,        32'hDEADBEEF, 4'd5},
        '{1'b1, 9'h094, 32'h000000FF, 32'h0,        4'd6},  // R6 window hole
        '{1'b0, 9'h094, 32'h0,        32'h0,        4'd6},
        '{1'b0, 9'h09C, 32'h0,        32'h0,        4'd6},
        '{1'b1, 9'h0A4, 32'h00000000, 32'h0,        4'd4},  // R4 bank17 dir
        '{1'b1, 9'h0A0, 32'h00000081, 32'h0,        4'd4},
        '{1'b0, 9'h0A0, 32'h0,        32'h00000081, 4'd4},
        '{1'b0, 9'h0A4, 32'h0,        32'h00000000, 4'd4},
        '{1'b1, 9'h0B4, 32'h00000055, 32'h0,        4'd4},  // bank19 dir
        '{1'b0, 9'h0B4, 32'h0,        32'h00000055, 4'd4},
        '{1'b1, 9'h0B8, 32'h00000012, 32'h0,        4'd6},  // beyond last bank
        '{1'b0, 9'h0B8, 32'h0,        32'h0,        4'd6},
        '{1'b0, 9'h000, 32'h0,        32'h0,        4'd6},
        '{1'b0, 9'h08C, 32'h0,        32'h00000000, 4'd6},
        '{1'b1, 9'h00C, 32'hFFFFFF00, 32'h0,        4'd7},
        '{1'b0, 9'h00C, 32'h0,        32'h00000000, 4'd7},
        '{1'b0, 9'h008, 32'h0,        32'h000000A5, 4'd9}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [8:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out;
    logic [NL-1:0] pin_oe;
    logic [31:0]   irq_en;
    logic [31:0]   rd;
    int            checks = 0;
    int            fails = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_BANKS(NB)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq_en  (irq_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Called at a negedge; returns at a negedge with the bus idle.
    task automatic xfer(input logic w, input logic [8:0] a, input logic [31:0] d,
                        output logic [31:0] r);
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
        @(negedge clk);
        check("R2 wait-cycle pready", {31'b0, pready}, 32'd0);
        check("R2 prdata zero while not ready", prdata, 32'd0);
        penable = 1'b1;
        @(negedge clk);
        check("R2 completion pready", {31'b0, pready}, 32'd1);
        r = prdata;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pin_oe low", {31'b0, |pin_oe}, 32'd0);
        check("R1 pin_out low", {31'b0, |pin_out}, 32'd0);
        check("R1 irq_en zero", irq_en, 32'd0);
        xfer(1'b0, 9'h034, 32'h0, rd);
        check("R1 bank5 dir reads FF", rd, 32'h000000FF);
        xfer(1'b0, 9'h030, 32'h0, rd);
        check("R1 bank5 data zero", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i].wr, VEC[i].addr, VEC[i].wdata, rd);
            if (!VEC[i].wr)
                check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].expv);
        end

        // R8 line-to-pin mapping
        check("R8 bank0 oe",   {24'b0, pin_oe[7:0]},     32'hFF);
        check("R8 bank0 out",  {24'b0, pin_out[7:0]},    32'hA5);
        check("R8 bank1 oe",   {24'b0, pin_oe[15:8]},    32'h00);
        check("R8 bank16 oe",  {24'b0, pin_oe[135:128]}, 32'hFF);
        check("R8 bank16 out", {24'b0, pin_out[135:128]},32'h3C);
        check("R8 bank17 out", {24'b0, pin_out[143:136]},32'h81);
        check("R8 bank19 oe",  {24'b0, pin_oe[159:152]}, 32'hAA);
        check("R5 irq_en port", irq_en, 32'hDEADBEEF);

        // R9 mixed directions in bank19
        xfer(1'b1, 9'h0B0, 32'h000000F0, rd);
        pin_in[159:152] = 8'h0F;
        repeat (3) @(negedge clk);
        xfer(1'b0, 9'h0B0, 32'h0, rd);
        check("R9 mixed bank19", rd, 32'h000000A5);

        // R9 plain input sampling, bank2
        pin_in[23:16] = 8'h6B;
        repeat (3) @(negedge clk);
        xfer(1'b0, 9'h018, 32'h0, rd);
        check("R9 bank2 pins", rd, 32'h0000006B);

        // R9 synchronizer latency, bank3
        pin_in[31:24] = 8'h99;
        xfer(1'b0, 9'h020, 32'h0, rd);
        check("R9 change not yet visible", rd, 32'h0);
        xfer(1'b0, 9'h020, 32'h0, rd);
        check("R9 change visible later", rd, 32'h00000099);

        // R10 abandoned transfer after setup
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 9'h090; pwdata = 32'h1;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        check("R10 no ready on abort", {31'b0, pready}, 32'd0);
        @(negedge clk);
        xfer(1'b0, 9'h090, 32'h0, rd);
        check("R10 abort kept irq word", rd, 32'hDEADBEEF);

        // R10 enable phase with no setup
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 9'h0A0; pwdata = 32'h7E;
        @(negedge clk);
        check("R10 no ready without setup", {31'b0, pready}, 32'd0);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        check("R10 bank17 out unchanged", {24'b0, pin_out[143:136]}, 32'h81);
        xfer(1'b0, 9'h0A0, 32'h0, rd);
        check("R10 bank17 data unchanged", rd, 32'h00000081);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule